// File: doc/BRIEF.md
# Banked Stack Pointer Selector

This block holds the hardware stack pointers of a processor core: a user pointer, a master (supervisor) pointer and an interrupt pointer. Only one of them is live at a time. The live pointer sits in a working register, A7, which the core reads and writes through a dedicated port. The other two sit in a small bank.

When the core asks for a switch, the block saves A7 into the bank slot of the pointer that is active now. The core raises that request after changing the privilege bits or writing the cache-control register. In the same clock the block picks a new slot from the supervisor bit, the master bit and a master-stack feature flag, then loads A7 from that slot.

A side port serves control-register moves. It reads and writes any banked slot by code. A read of the active slot returns A7, and a write to the active slot also updates A7, so the bank and the working register never disagree.

Slot codes used on every port: user = 0, master = 1, interrupt = 2. Code 3 names no slot.

Top module: `sp_bank_top`

## Requirements
- R1: After reset the active slot is master (code 1), A7 reads zero and every slot reads zero.
- R2: A switch with the supervisor bit clear makes the user slot (code 0) active.
- R3: A switch with the supervisor bit set selects the master slot when the feature flag is clear, whatever the master bit is. It also selects the master slot when the master bit is set.
- R4: A switch with the supervisor bit set, the feature flag set and the master bit clear makes the interrupt slot (code 2) active.
- R5: On a switch, the value A7 held is written into the slot that was active before the switch. A later side-port read of that slot returns it.
- R6: A switch completes in one clock. On the next cycle A7 holds the stored value of the newly active slot.
- R7: A switch that selects the slot already active leaves A7 unchanged.
- R8: A side-port write with code 0, 1 or 2 stores the data in that slot. When that slot is active, A7 takes the data on the next cycle.
- R9: A side-port read of the active slot returns A7. A read with code 3 returns zero. A write with code 3 changes nothing.
- R10: An A7 write without a switch updates A7 and leaves the active slot unchanged. Without a switch the active slot never changes.
- R11: Within one cycle, an A7 write is applied first, then the switch save. A side-port write overrides the save, and the load of A7 sees the side-port data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_req | input | 1 | Switch request |
| sup_mode | input | 1 | Supervisor bit |
| master_mode | input | 1 | Master bit |
| msp_present | input | 1 | Master-stack feature flag |
| a7_we | input | 1 | A7 write enable |
| a7_wdata | input | DATA_W | A7 write data |
| a7_q | output | DATA_W | Working register A7 |
| active_slot | output | 2 | Code of the active slot |
| cr_we | input | 1 | Side-port write enable |
| cr_code | input | 2 | Side-port write slot code |
| cr_wdata | input | DATA_W | Side-port write data |
| cr_rcode | input | 2 | Side-port read slot code |
| cr_rdata | output | DATA_W | Side-port read data |

## Verification
The bench goes after the selection corners.

- Feature flag off with the master bit set or clear must always land on the master slot. A design that honoured the master bit there would load the interrupt pointer instead.
- A same-slot switch must keep A7. A design that reloaded from the stale bank copy would lose the latest A7 value.
- Same-cycle collisions are exercised: an A7 write together with a switch, and a side-port write to the slot being left or entered. A wrong priority shows up as a stale saved value or a stale A7.
- Reads of the active slot must return A7. A design that read the bank directly would return an old value.

// File: rtl/sp_bank_pkg.sv
package sp_bank_pkg;
  localparam int NUM_SLOTS = 3;
  localparam int SLOT_W    = 2;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_USR  = 2'd0,
    SLOT_MST  = 2'd1,
    SLOT_IRQ  = 2'd2,
    SLOT_NONE = 2'd3
  } slot_e;
endpackage

// File: rtl/sp_slot_pick.sv
module sp_slot_pick
  import sp_bank_pkg::*;
(
  input  logic  sup_mode,
  input  logic  master_mode,
  input  logic  msp_present,
  output slot_e pick
);
  always_comb begin
    if (!sup_mode)
      pick = SLOT_USR;
    else if (!msp_present || master_mode)
      pick = SLOT_MST;
    else
      pick = SLOT_IRQ;
  end
endmodule

// File: rtl/sp_bank_store.sv
module sp_bank_store
  import sp_bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              save_en,
  input  slot_e                             save_idx,
  input  logic [DATA_W-1:0]                 save_data,
  input  logic                              wr_en,
  input  slot_e                             wr_idx,
  input  logic [DATA_W-1:0]                 wr_data,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0]  slot_q
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic hit_wr, hit_save;
    assign hit_wr   = wr_en   && (wr_idx   == slot_e'(g));
    assign hit_save = save_en && (save_idx == slot_e'(g));

    always_ff @(posedge clk) begin
      if (rst)
        slot_q[g] <= '0;
      else if (hit_wr)
        slot_q[g] <= wr_data;
      else if (hit_save)
        slot_q[g] <= save_data;
    end
  end
endmodule

// File: rtl/sp_bank_top.sv
module sp_bank_top
  import sp_bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_req,
  input  logic              sup_mode,
  input  logic              master_mode,
  input  logic              msp_present,
  input  logic              a7_we,
  input  logic [DATA_W-1:0] a7_wdata,
  output logic [DATA_W-1:0] a7_q,
  output logic [1:0]        active_slot,
  input  logic              cr_we,
  input  logic [1:0]        cr_code,
  input  logic [DATA_W-1:0] cr_wdata,
  input  logic [1:0]        cr_rcode,
  output logic [DATA_W-1:0] cr_rdata
);
  slot_e                            act_q, pick, act_d;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_q;
  logic [DATA_W-1:0]                a7_eff, a7_d;
  logic                             wr_ok;
  slot_e                            wr_idx, rd_idx;

  assign wr_idx = slot_e'(cr_code);
  assign rd_idx = slot_e'(cr_rcode);
  assign wr_ok  = cr_we && (wr_idx != SLOT_NONE);
  assign a7_eff = a7_we ? a7_wdata : a7_q;

  sp_slot_pick u_pick (
    .sup_mode    (sup_mode),
    .master_mode (master_mode),
    .msp_present (msp_present),
    .pick        (pick)
  );

  sp_bank_store #(.DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .save_en   (sw_req),
    .save_idx  (act_q),
    .save_data (a7_eff),
    .wr_en     (wr_ok),
    .wr_idx    (wr_idx),
    .wr_data   (cr_wdata),
    .slot_q    (slot_q)
  );

  // Next active slot and next A7 value.
  always_comb begin
    act_d = sw_req ? pick : act_q;
    if (wr_ok && (wr_idx == act_d))
      a7_d = cr_wdata;
    else if (!sw_req || (act_d == act_q))
      a7_d = a7_eff;
    else
      a7_d = slot_q[act_d];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= SLOT_MST;
      a7_q  <= '0;
    end else begin
      act_q <= act_d;
      a7_q  <= a7_d;
    end
  end

  // Side-port read; the active slot is served from A7.
  always_comb begin
    if (rd_idx == SLOT_NONE)
      cr_rdata = '0;
    else if (rd_idx == act_q)
      cr_rdata = a7_q;
    else
      cr_rdata = slot_q[rd_idx];
  end

  assign active_slot = act_q;
endmodule

// File: rtl/sp_bank_checker.sv
module sp_bank_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              sw_req,
  input logic              sup_mode,
  input logic              master_mode,
  input logic              msp_present,
  input logic              a7_we,
  input logic [DATA_W-1:0] a7_q,
  input logic [1:0]        active_slot,
  input logic              cr_we,
  input logic [1:0]        cr_code,
  input logic [DATA_W-1:0] cr_wdata
);
  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) && !rst |-> (active_slot == 2'd1 && a7_q == '0));

  assert_user_pick_R2: assert property (@(posedge clk) disable iff (rst)
    sw_req && !sup_mode |=> active_slot == 2'd0);

  assert_master_pick_R3: assert property (@(posedge clk) disable iff (rst)
    sw_req && sup_mode && (!msp_present || master_mode) |=> active_slot == 2'd1);

  assert_irq_pick_R4: assert property (@(posedge clk) disable iff (rst)
    sw_req && sup_mode && msp_present && !master_mode |=> active_slot == 2'd2);

  assert_same_slot_keeps_a7_R7: assert property (@(posedge clk) disable iff (rst)
    sw_req && !sup_mode && active_slot == 2'd0 && !a7_we && !cr_we |=> $stable(a7_q));

  assert_active_write_R8: assert property (@(posedge clk) disable iff (rst)
    cr_we && !sw_req && cr_code == active_slot && cr_code != 2'd3
    |=> a7_q == $past(cr_wdata));

  assert_slot_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !sw_req |=> $stable(active_slot));

  assert_slot_valid_R10: assert property (@(posedge clk) disable iff (rst)
    active_slot != 2'd3);
endmodule

bind sp_bank_top sp_bank_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sw_req      (sw_req),
  .sup_mode    (sup_mode),
  .master_mode (master_mode),
  .msp_present (msp_present),
  .a7_we       (a7_we),
  .a7_q        (a7_q),
  .active_slot (active_slot),
  .cr_we       (cr_we),
  .cr_code     (cr_code),
  .cr_wdata    (cr_wdata)
);

// File: tb/tb_sp_bank_top.sv
module tb_sp_bank_top;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          sw_req, sup_mode, master_mode, msp_present;
  logic          a7_we, cr_we;
  logic [DW-1:0] a7_wdata, cr_wdata;
  logic [1:0]    cr_code, cr_rcode;
  logic [DW-1:0] a7_q, cr_rdata;
  logic [1:0]    active_slot;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  // Reference state
  logic [DW-1:0] m_bank [3];
  logic [DW-1:0] m_a7;
  int            m_act;

  always #10 clk = ~clk;

  sp_bank_top #(.DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .sw_req(sw_req), .sup_mode(sup_mode),
    .master_mode(master_mode), .msp_present(msp_present),
    .a7_we(a7_we), .a7_wdata(a7_wdata), .a7_q(a7_q),
    .active_slot(active_slot), .cr_we(cr_we), .cr_code(cr_code),
    .cr_wdata(cr_wdata), .cr_rcode(cr_rcode), .cr_rdata(cr_rdata)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d cycles, expected fewer than 100000", cycles);
        finish_run();
      end
    end
  end

  task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference model update for one clock edge with the current inputs.
  task automatic model_edge();
    logic [DW-1:0] eff;
    int            nxt;
    if (rst) begin
      for (int i = 0; i < 3; i++) m_bank[i] = '0;
      m_a7 = '0; m_act = 1;
      return;
    end
    eff = a7_we ? a7_wdata : m_a7;
    m_a7 = eff;
    nxt = m_act;
    if (sw_req) begin
      m_bank[m_act] = eff;
      if (!sup_mode) nxt = 0;
      else if (!msp_present || master_mode) nxt = 1;
      else nxt = 2;
    end
    if (cr_we && cr_code != 2'd3) m_bank[cr_code] = cr_wdata;
    if (nxt != m_act || (cr_we && int'(cr_code) == nxt)) m_a7 = m_bank[nxt];
    m_act = nxt;
  endtask

  function automatic logic [DW-1:0] model_read(logic [1:0] c);
    if (c == 2'd3) return '0;
    if (int'(c) == m_act) return m_a7;
    return m_bank[c];
  endfunction

  // One cycle: inputs already driven; clock, update model, compare at negedge.
  task automatic cycle(string req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(req, "a7", a7_q, m_a7);
    check(req, "active", {30'd0, active_slot}, DW'(m_act));
    check(req, "read", cr_rdata, model_read(cr_rcode));
  endtask

  task automatic idle();
    sw_req = 0; a7_we = 0; cr_we = 0;
  endtask

  task automatic do_switch(bit s, bit m, bit f, string req);
    idle(); sw_req = 1; sup_mode = s; master_mode = m; msp_present = f;
    cycle(req);
    idle();
  endtask

  task automatic bank_wr(logic [1:0] c, logic [DW-1:0] d, string req);
    idle(); cr_we = 1; cr_code = c; cr_wdata = d;
    cycle(req);
    idle();
  endtask

  initial begin
    idle();
    sup_mode = 1; master_mode = 0; msp_present = 0;
    a7_wdata = '0; cr_code = 0; cr_wdata = '0; cr_rcode = 0;
    rst = 1;
    @(negedge clk);
    cycle("R1");
    rst = 0;
    // R1: every slot reads zero after reset
    for (int c = 0; c < 4; c++) begin
      cr_rcode = 2'(c);
      cycle("R1");
    end
    // R8: load each slot; write to the active master slot reaches A7
    cr_rcode = 2'd1;
    bank_wr(2'd0, 32'h0000_1000, "R8");
    bank_wr(2'd2, 32'h0000_3000, "R8");
    bank_wr(2'd1, 32'h0000_2000, "R8");
    // R9: code 3 write is ignored
    cr_rcode = 2'd3;
    bank_wr(2'd3, 32'hDEAD_BEEF, "R9");
    cr_rcode = 2'd2;
    cycle("R9");
    // R10: A7 write without switch
    idle(); a7_we = 1; a7_wdata = 32'h0000_2222; cycle("R10"); idle();
    // R3/R7: feature absent, master bit clear -> stays master, A7 kept
    do_switch(1, 0, 0, "R3");
    do_switch(1, 1, 0, "R7");
    // R2/R5/R6: to user; master slot holds saved A7
    cr_rcode = 2'd1;
    do_switch(0, 0, 0, "R5");
    cr_rcode = 2'd0;
    cycle("R6");
    // R4: interrupt slot
    do_switch(1, 0, 1, "R4");
    // R3: master bit set with feature on
    do_switch(1, 1, 1, "R3");
    // R2: back to user
    do_switch(0, 1, 1, "R2");
    // R11: A7 write plus switch, side write to the slot being entered
    idle(); sw_req = 1; sup_mode = 1; master_mode = 0; msp_present = 1;
    a7_we = 1; a7_wdata = 32'h0000_7777;
    cr_we = 1; cr_code = 2'd2; cr_wdata = 32'h0000_9999;
    cr_rcode = 2'd0;
    cycle("R11");
    idle();
    // R11: side write to the slot being left overrides the save
    idle(); sw_req = 1; sup_mode = 0; a7_we = 1; a7_wdata = 32'h0000_5555;
    cr_we = 1; cr_code = 2'd2; cr_wdata = 32'h0000_4444; cr_rcode = 2'd2;
    cycle("R11");
    idle(); cycle("R11");
    // Mixed traffic
    for (int i = 0; i < 3000; i++) begin
      sw_req      = ($urandom % 3) == 0;
      sup_mode    = $urandom % 2;
      master_mode = $urandom % 2;
      msp_present = $urandom % 2;
      a7_we       = ($urandom % 3) == 0;
      a7_wdata    = $urandom;
      cr_we       = ($urandom % 3) == 0;
      cr_code     = 2'($urandom % 4);
      cr_wdata    = $urandom;
      cr_rcode    = 2'($urandom % 4);
      cycle("R11");
    end
    idle();
    // R1: reset again mid-run
    rst = 1; cycle("R1"); rst = 0;
    cr_rcode = 2'd0; cycle("R1");
    finish_run();
  end
endmodule